// File: doc/BRIEF.md
# Bus-to-Host DMA Address Translator

The block sits between the I/O bus side and the host interconnect. It turns the 32-bit address of each device DMA request into a 48-bit host address. Each request falls into one of three windows. The low window passes through untranslated. The middle window is translated page by page through a table of translation entries. The top window is rebased in large segments by a single direct-map register.

Requests enter and leave through a valid/ready pair, and the result is registered one clock after acceptance. With each translated address the block reports the target port identifier, the attribute bits of the entry used, the window the request fell into, and two fault flags. A configuration port loads translation entries as whole 64-bit words and loads the direct-map register. It also reads either one back combinationally, with an entry returned in 32-bit halves.

Top module: `xlat_dma_top`

## Requirements
- R1: After reset `rsp_valid_o` is 0, `req_ready_o` is 1, every table entry reads back as zero and the direct-map register reads back as zero.
- R2: A bus address below 0x4000_0000 is local. The region code is 0, the host address is the bus address zero-extended, target and attributes are 0, and neither fault is raised.
- R3: A bus address in 0x4000_0000..0x7FFF_FFFF is mapped, with region code 1. The entry index is address bits 18:12. The host address is entry bits 47:12 followed by address bits 11:0. The target is entry bits 11:8. The attributes are entry bits 4:0, where bit 0 is valid, bit 1 coherent, bit 2 precise, bit 3 prefetch and bit 4 BAR.
- R4: A mapped lookup that hits an entry whose valid bit (bit 0) is clear raises `rsp_inval_o`. The host address, target and attributes are then all zero.
- R5: A mapped address with any of bits 29:19 set lies beyond the 128-entry table. It raises `rsp_range_o` and no invalid fault, with host address, target and attributes zero.
- R6: A bus address at 0x8000_0000 or above is direct, with region code 2. The host address is (direct-map bits 16:0 × 2^31 + bus bits 30:0 + RAM_BASE) mod 2^48. The target is direct-map bits 23:20, and the attributes are 0.
- R7: A direct-map write with `cfg_wsel_i`=1 loads `cfg_wdata_i[31:0]` into the register. Bits 16:0 (offset), 17 (add-512 control), 18 (64-bit read-modify-write control) and 23:20 (target) are kept. Bits 19 and 31:24 read back as 0 on `cfg_rsel_i`=2.
- R8: An entry write with `cfg_wsel_i`=0 stores bits 47:0 of the 64-bit word at `cfg_widx_i`. The low window (`cfg_rsel_i`=0) reads back bits 31:0. The high window (`cfg_rsel_i`=1) reads back bits 47:32, with bits 31:16 of the read data zero.
- R9: A request accepted at a clock edge yields `rsp_valid_o`=1 after that edge. The response and its fields stay stable while `rsp_ready_i` is low. `req_ready_o` is 1 exactly when no response is pending or the pending one is being taken.
- R10: A lookup accepted in the same cycle as a write to its entry uses the old entry. Lookups accepted later use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | 32 | Bus address to translate |
| rsp_valid_o | output | 1 | Result present |
| rsp_ready_i | input | 1 | Result consumed |
| rsp_addr_o | output | 48 | Host address |
| rsp_tgt_o | output | 4 | Target port identifier |
| rsp_attr_o | output | 5 | Entry attribute bits |
| rsp_region_o | output | 2 | 0 local, 1 mapped, 2 direct |
| rsp_range_o | output | 1 | Mapped page beyond the table |
| rsp_inval_o | output | 1 | Mapped entry not valid |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wsel_i | input | 1 | 0 entry, 1 direct-map register |
| cfg_widx_i | input | 7 | Entry index for writes |
| cfg_wdata_i | input | 64 | Write data |
| cfg_rsel_i | input | 2 | 0 entry low, 1 entry high, 2 direct map |
| cfg_ridx_i | input | 7 | Entry index for reads |
| cfg_rdata_o | output | 32 | Read data |

## Verification
The assertions assume that `rsp_ready_i` and the configuration inputs are driven to known values in every cycle after reset. They also assume that a request is not withdrawn in a way that matters to the pipeline. The stable-hold check relies on the responder being able to stall arbitrarily.

The stimulus changes inputs only at the falling edge. It keeps `rsp_ready_i` high apart from one deliberate stall sequence. Random addresses are steered into each window, including mapped pages beyond the table, so that every fault path is reached while the inputs stay legal.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int BUS_AW  = 32;
  localparam int HOST_AW = 48;
  localparam int ENT_W   = 48;
  localparam int PG_SH   = 12;

  typedef enum logic [1:0] {
    RGN_LOCAL  = 2'd0,
    RGN_MAPPED = 2'd1,
    RGN_DIRECT = 2'd2
  } rgn_e;

  typedef struct packed {
    logic [HOST_AW-1:0] addr;
    logic [3:0]         tgt;
    logic [4:0]         attr;
    rgn_e               rgn;
    logic               f_range;
    logic               f_inval;
  } xlat_res_t;
endpackage

// File: rtl/xlat_region_decode.sv
module xlat_region_decode
  import xlat_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic [BUS_AW-1:0] addr_i,
  output rgn_e              rgn_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              range_o
);
  localparam int HI_LSB = PG_SH + IDX_W;

  logic over;

  always_comb begin
    if (addr_i[31])      rgn_o = RGN_DIRECT;
    else if (addr_i[30]) rgn_o = RGN_MAPPED;
    else                 rgn_o = RGN_LOCAL;
  end

  assign idx_o = addr_i[PG_SH +: IDX_W];

  generate
    if (HI_LSB < 30) begin : g_chk
      assign over = |addr_i[29:HI_LSB];
    end else begin : g_nochk
      assign over = 1'b0;
    end
  endgenerate

  assign range_o = (rgn_o == RGN_MAPPED) && over;
endmodule

// File: rtl/xlat_entry_table.sv
module xlat_entry_table
  import xlat_pkg::*;
#(
  parameter int N_ENT = 128,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] lidx_i,
  output logic [ENT_W-1:0] lent_o,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [ENT_W-1:0] rent_o
);
  logic [ENT_W-1:0] mem_q [N_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign lent_o = mem_q[lidx_i];
  assign rent_o = mem_q[ridx_i];

  p_write_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/xlat_direct_map.sv
module xlat_direct_map
  import xlat_pkg::*;
#(
  parameter logic [HOST_AW-1:0] RAM_BASE = 48'h0000_2000_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [31:0]        wdata_i,
  input  logic [BUS_AW-1:0]  addr_i,
  output logic [HOST_AW-1:0] host_o,
  output logic [3:0]         tgt_o,
  output logic [31:0]        reg_o
);
  localparam logic [31:0] KEEP = 32'h00F7_FFFF;
  localparam int OFF_W = HOST_AW - 31;

  logic [31:0] dm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dm_q <= '0;
    else if (we_i) dm_q <= wdata_i & KEEP;
  end

  // offset lsb lands on host bit 31
  assign host_o = {dm_q[OFF_W-1:0], addr_i[30:0]} + RAM_BASE;
  assign tgt_o  = dm_q[23:20];
  assign reg_o  = dm_q;
endmodule

// File: rtl/xlat_dma_top.sv
module xlat_dma_top
  import xlat_pkg::*;
#(
  parameter int                 N_ENT    = 128,
  parameter logic [HOST_AW-1:0] RAM_BASE = 48'h0000_2000_0000,
  localparam int                IDX_W    = $clog2(N_ENT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [31:0]        req_addr_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [47:0]        rsp_addr_o,
  output logic [3:0]         rsp_tgt_o,
  output logic [4:0]         rsp_attr_o,
  output logic [1:0]         rsp_region_o,
  output logic               rsp_range_o,
  output logic               rsp_inval_o,
  input  logic               cfg_we_i,
  input  logic               cfg_wsel_i,
  input  logic [IDX_W-1:0]   cfg_widx_i,
  input  logic [63:0]        cfg_wdata_i,
  input  logic [1:0]         cfg_rsel_i,
  input  logic [IDX_W-1:0]   cfg_ridx_i,
  output logic [31:0]        cfg_rdata_o
);
  rgn_e               rgn;
  logic [IDX_W-1:0]   lidx;
  logic               range_flt;
  logic [ENT_W-1:0]   lent, rent;
  logic [HOST_AW-1:0] dir_host;
  logic [3:0]         dir_tgt;
  logic [31:0]        dm_reg;
  xlat_res_t          res_d, res_q;
  logic               vld_q, accept;

  xlat_region_decode #(.IDX_W(IDX_W)) u_dec (
    .addr_i (req_addr_i),
    .rgn_o  (rgn),
    .idx_o  (lidx),
    .range_o(range_flt)
  );

  xlat_entry_table #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i && !cfg_wsel_i),
    .widx_i (cfg_widx_i),
    .wdata_i(cfg_wdata_i[ENT_W-1:0]),
    .lidx_i (lidx),
    .lent_o (lent),
    .ridx_i (cfg_ridx_i),
    .rent_o (rent)
  );

  xlat_direct_map #(.RAM_BASE(RAM_BASE)) u_dir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i && cfg_wsel_i),
    .wdata_i(cfg_wdata_i[31:0]),
    .addr_i (req_addr_i),
    .host_o (dir_host),
    .tgt_o  (dir_tgt),
    .reg_o  (dm_reg)
  );

  always_comb begin
    res_d     = '0;
    res_d.rgn = rgn;
    unique case (rgn)
      RGN_LOCAL: res_d.addr = HOST_AW'(req_addr_i);
      RGN_MAPPED: begin
        if (range_flt)    res_d.f_range = 1'b1;
        else if (!lent[0]) res_d.f_inval = 1'b1;
        else begin
          res_d.addr = {lent[ENT_W-1:PG_SH], req_addr_i[PG_SH-1:0]};
          res_d.tgt  = lent[11:8];
          res_d.attr = lent[4:0];
        end
      end
      default: begin
        res_d.addr = dir_host;
        res_d.tgt  = dir_tgt;
      end
    endcase
  end

  assign req_ready_o = !vld_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      res_q <= res_d;
    end else if (rsp_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign rsp_valid_o  = vld_q;
  assign rsp_addr_o   = res_q.addr;
  assign rsp_tgt_o    = res_q.tgt;
  assign rsp_attr_o   = res_q.attr;
  assign rsp_region_o = res_q.rgn;
  assign rsp_range_o  = res_q.f_range;
  assign rsp_inval_o  = res_q.f_inval;

  always_comb begin
    unique case (cfg_rsel_i)
      2'd0:    cfg_rdata_o = rent[31:0];
      2'd1:    cfg_rdata_o = 32'(rent[ENT_W-1:32]);
      2'd2:    cfg_rdata_o = dm_reg;
      default: cfg_rdata_o = '0;
    endcase
  end

  p_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_addr_o)
      && $stable(rsp_tgt_o) && $stable(rsp_region_o));
  p_fault_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_range_o || rsp_inval_o) |-> rsp_addr_o == '0 && rsp_attr_o == '0);
  p_fault_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_range_o, rsp_inval_o}) <= 1);
  p_range_mapped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_range_o || rsp_inval_o) |-> rsp_region_o == 2'd1);
  p_local_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_region_o == 2'd0 |-> rsp_addr_o[47:30] == '0 && !rsp_range_o && !rsp_inval_o);
endmodule

// File: tb/xlat_dma_top_test.sv
module xlat_dma_top_test;
  localparam logic [47:0] RB = 48'h0000_2000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [47:0] rsp_addr;
  logic [3:0]  rsp_tgt;
  logic [4:0]  rsp_attr;
  logic [1:0]  rsp_region;
  logic        rsp_range, rsp_inval;
  logic        cfg_we = 1'b0, cfg_wsel = 1'b0;
  logic [6:0]  cfg_widx = '0, cfg_ridx = '0;
  logic [63:0] cfg_wdata = '0;
  logic [1:0]  cfg_rsel = '0;
  logic [31:0] cfg_rdata;

  int total = 0, bad = 0;
  logic [47:0] mdl [128];
  logic [31:0] mdm = '0;

  always #10 clk = ~clk;

  xlat_dma_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_addr_o(rsp_addr), .rsp_tgt_o(rsp_tgt), .rsp_attr_o(rsp_attr),
    .rsp_region_o(rsp_region), .rsp_range_o(rsp_range), .rsp_inval_o(rsp_inval),
    .cfg_we_i(cfg_we), .cfg_wsel_i(cfg_wsel), .cfg_widx_i(cfg_widx),
    .cfg_wdata_i(cfg_wdata), .cfg_rsel_i(cfg_rsel), .cfg_ridx_i(cfg_ridx),
    .cfg_rdata_o(cfg_rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // packed expectation: {addr48, tgt4, attr5, rgn2, range, inval}
  function automatic logic [60:0] expect_of(input logic [31:0] a);
    logic [47:0] h; logic [3:0] t; logic [4:0] at; logic [1:0] r; logic fr, fi;
    logic [47:0] e;
    h = '0; t = '0; at = '0; fr = 0; fi = 0;
    if (a < 32'h4000_0000) begin
      r = 2'd0; h = {16'h0, a};
    end else if (a < 32'h8000_0000) begin
      r = 2'd1;
      e = mdl[a[18:12]];
      if (a[29:19] != 0) fr = 1;
      else if (!e[0]) fi = 1;
      else begin h = {e[47:12], a[11:0]}; t = e[11:8]; at = e[4:0]; end
    end else begin
      r = 2'd2;
      h = (48'(mdm[16:0]) << 31) + 48'(a[30:0]) + RB;
      t = mdm[23:20];
    end
    return {h, t, at, r, fr, fi};
  endfunction

  function automatic logic [60:0] got();
    return {rsp_addr, rsp_tgt, rsp_attr, rsp_region, rsp_range, rsp_inval};
  endfunction

  function automatic string tag_of(input logic [60:0] e);
    if (e[0]) return "R4";
    if (e[1]) return "R5";
    case (e[3:2])
      2'd0: return "R2";
      2'd1: return "R3";
      default: return "R6";
    endcase
  endfunction

  task automatic wr_ent(input logic [6:0] i, input logic [63:0] d);
    @(negedge clk); cfg_we = 1; cfg_wsel = 0; cfg_widx = i; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    mdl[i] = d[47:0];
  endtask

  task automatic wr_dm(input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_wsel = 1; cfg_wdata = {32'h0, d};
    @(negedge clk); cfg_we = 0;
    mdm = d & 32'h00F7_FFFF;
  endtask

  task automatic rd(input logic [1:0] s, input logic [6:0] i, input logic [31:0] exp, input string req);
    cfg_rsel = s; cfg_ridx = i; #1;
    chk(req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic look(input logic [31:0] a);
    logic [60:0] e;
    @(negedge clk); req_valid = 1; req_addr = a;
    e = expect_of(a);
    @(negedge clk); req_valid = 0;
    chk("R9 valid", 64'(rsp_valid), 64'd1);
    chk(tag_of(e), 64'(got()), 64'(e));
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [60:0] ea, eb;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 0);
    chk("R1 req_ready", 64'(req_ready), 1);
    rd(2'd0, 7'd5, 32'h0, "R1 entry lo");
    rd(2'd1, 7'd127, 32'h0, "R1 entry hi");
    rd(2'd2, 7'd0, 32'h0, "R1 dirmap");

    // directed
    look(32'h0000_0000);
    look(32'h3FFF_FFFF);
    look(32'h4000_3ABC);                     // R4 entry 3 invalid
    wr_ent(7'd3, 64'hFFFF_ABCD_1234_5A1F);
    rd(2'd0, 7'd3, 32'h1234_5A1F, "R8 lo");
    rd(2'd1, 7'd3, 32'h0000_ABCD, "R8 hi");
    look(32'h4000_3ABC);                     // R3 hit
    wr_ent(7'd127, 64'h0000_0001_0000_0F01);
    look(32'h4007_FFFF);                     // R3 last entry
    look(32'h4008_0000);                     // R5 first out of range
    look(32'h7FFF_FFFF);                     // R5
    look(32'h8000_0000);                     // R6 zero offset
    wr_dm(32'hFFFF_FFFF);
    rd(2'd2, 7'd0, 32'h00F7_FFFF, "R7 mask");
    look(32'hFFFF_FFFF);                     // R6 wrap
    wr_dm(32'h0050_0003);
    rd(2'd2, 7'd0, 32'h0050_0003, "R7 readback");
    look(32'h8123_4567);

    // R10 same-cycle write and lookup
    @(negedge clk);
    ea = expect_of(32'h4000_3010);
    cfg_we = 1; cfg_wsel = 0; cfg_widx = 7'd3; cfg_wdata = 64'h0000_0000_7777_0701;
    req_valid = 1; req_addr = 32'h4000_3010;
    @(negedge clk); cfg_we = 0; req_valid = 0;
    mdl[3] = 48'h0000_7777_0701;
    chk("R10 old entry", 64'(got()), 64'(ea));
    look(32'h4000_3010);                     // R10 new entry

    // R9 stall and hold
    ea = expect_of(32'h1234_5678);
    eb = expect_of(32'h4000_3FFF);
    @(negedge clk); rsp_ready = 0; req_valid = 1; req_addr = 32'h1234_5678;
    @(negedge clk); req_addr = 32'h4000_3FFF;
    chk("R9 stall ready", 64'(req_ready), 0);
    chk("R9 first", 64'(got()), 64'(ea));
    @(negedge clk);
    chk("R9 held", 64'(got()), 64'(ea));
    chk("R9 held valid", 64'(rsp_valid), 1);
    rsp_ready = 1;
    @(negedge clk); req_valid = 0;
    chk("R9 second", 64'(got()), 64'(eb));
    @(negedge clk);
    chk("R9 drained", 64'(rsp_valid), 0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned k;
      logic [31:0] a;
      k = $urandom % 10;
      if (k < 2) wr_ent(7'($urandom), {$urandom, $urandom});
      else if (k == 2) wr_dm($urandom);
      else if (k == 3) begin
        logic [6:0] ix;
        ix = 7'($urandom);
        @(negedge clk);
        rd(2'd0, ix, mdl[ix][31:0], "R8 rand lo");
        rd(2'd1, ix, 32'(mdl[ix][47:32]), "R8 rand hi");
      end else begin
        a = $urandom;
        if (k == 4) a = {2'b01, 11'h0, a[18:0]};
        look(a);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule